// File: doc/BRIEF.md
# Dual-Protocol Bus Acquisition Front End

This block sits between an on-chip DMA engine and a shared system bus and wins bus mastership on the engine's behalf. A static mode input picks one of two arbitration styles. In three-wire mode the block pulls an open-drain style request line low, waits for an active-low grant, and then claims the bus with an active-low grant-acknowledge. It claims only once the bus is seen to be quiet. In two-wire mode it drives a hold line high and waits for a hold-acknowledge.

The engine raises a request level and receives a `bus_owned_o` indication. It then pulses a done input to give the bus back. Every handshake input from the bus is resynchronised to the bus clock through a two-stage synchronizer before any decision uses it. Each tri-stateable line is presented as a value plus an output-enable, so that the pad ring can build the buffer.

Top module: `bus_arb_front`

## Requirements
- R1: A synchronous active-high reset puts the block in idle with req_oe_o=0, req_n_o=1, hold_o=0, hold_oe_o=0, gack_oe_o=0, gack_n_o=1 and bus_owned_o=0. Mode 1 (three-wire) is latched as the reset mode.
- R2: In mode 1, the request line is driven low (req_oe_o=1, req_n_o=0) from the cycle after dma_req_i is seen in idle until the claim. At all other times it is undriven (req_oe_o=0, req_n_o=1), and hold_oe_o=0.
- R3: In mode 0 (two-wire), hold_oe_o=1 at all times. hold_o=1 while a request or ownership is in progress and hold_o=0 in idle. req_oe_o stays 0.
- R4: In mode 1, the block claims the bus only on a cycle where all of the following are true of the synchronized inputs: grant_n=0, strobe_n=1, every bit of size_ack_n=1, and the sensed gack_n=1. When it claims, gack_oe_o=1 and gack_n_o=0 from the next cycle.
- R5: In mode 1, the request line is released (req_oe_o=0) in the same cycle that grant-acknowledge becomes driven.
- R6: In mode 0, ownership is taken when the synchronized hold_ack is 1, and hold_o stays 1 while the bus is owned.
- R7: Each bus handshake input passes two synchronizer flops. A change applied before clock edge k can first alter the claim decision at edge k+2, so the outputs change after edge k+2.
- R8: bus_owned_o rises one cycle after ownership is established in either mode. It falls in the same cycle the block releases the bus.
- R9: While owning, a dma_done_i seen at an edge returns the block to idle at that edge. In mode 1 grant-acknowledge becomes undriven; in mode 0 hold_o drops to 0.
- R10: mode_i is sampled only while idle. A change of mode_i during a request or ownership has no effect on the outputs until the block is idle again.
- R11: In mode 0, grant-acknowledge is never driven (gack_oe_o=0, gack_n_o=1).
- R12: If dma_req_i drops while a request is pending, the block returns to idle at that edge and stops requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 1 = three-wire protocol, 0 = two-wire protocol |
| dma_req_i | input | 1 | Engine wants the bus (level) |
| dma_done_i | input | 1 | Engine finished, give the bus back |
| grant_n_i | input | 1 | Potential grant, active low (mode 1) |
| hold_ack_i | input | 1 | Hold acknowledge, active high (mode 0) |
| strobe_n_i | input | 1 | Bus address strobe, active low |
| size_ack_n_i | input | ACK_W | Data-size acknowledges from the slave, active low |
| gack_n_i | input | 1 | Sensed state of the shared grant-acknowledge line, active low |
| req_n_o | output | 1 | Request line value (mode 1) |
| req_oe_o | output | 1 | Request line output enable |
| hold_o | output | 1 | Hold request value (mode 0) |
| hold_oe_o | output | 1 | Hold line output enable |
| gack_n_o | output | 1 | Grant-acknowledge value |
| gack_oe_o | output | 1 | Grant-acknowledge output enable |
| bus_owned_o | output | 1 | Bus ownership held, to the engine |

## Verification
The three-wire claim is first run with a clean grant and then with the grant held low while each of the four quiet conditions is broken one at a time. This separates a qualifier that checks all of them from one that skips a term or reads the wrong polarity. Counted cycles from a grant or hold-acknowledge edge to the claim show whether both synchronizer stages are present. A mode flip in the middle of a transfer and a request withdrawn before any grant exercise the idle-only mode latch and the abort path. A long run of biased random stimulus in both modes, compared every cycle against a behavioural model, covers orderings of done, grant and request that the directed cases miss.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

  // Three-wire claim rule: potential grant seen, strobe idle,
  // all size acknowledges idle, nobody else holding grant-acknowledge.
  function automatic logic claim_rule(input logic grant_n,
                                      input logic strobe_n,
                                      input logic sizes_idle,
                                      input logic other_gack_n);
    return (!grant_n) && strobe_n && sizes_idle && other_gack_n;
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/arb_qual.sv
module arb_qual #(
  parameter int ACK_W = 2
) (
  input  logic             grant_n_s,
  input  logic             strobe_n_s,
  input  logic [ACK_W-1:0] size_ack_n_s,
  input  logic             gack_n_s,
  output logic             claim_ok_o
);
  import arb_pkg::*;

  logic sizes_idle;
  assign sizes_idle = &size_ack_n_s;
  assign claim_ok_o = claim_rule(grant_n_s, strobe_n_s, sizes_idle, gack_n_s);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic dma_req_i,
  input  logic dma_done_i,
  input  logic claim_ok_i,
  input  logic hold_ack_s_i,
  output logic req_n_o,
  output logic req_oe_o,
  output logic hold_o,
  output logic hold_oe_o,
  output logic gack_n_o,
  output logic gack_oe_o,
  output logic bus_owned_o
);
  import arb_pkg::*;

  arb_state_e state, nxt;
  logic       mode_q;
  logic       owned_q;

  // named events for the assertions
  logic claim_evt;
  logic release_evt;
  logic withdraw_evt;
  logic grant_seen;

  assign grant_seen   = mode_q ? claim_ok_i : hold_ack_s_i;
  assign claim_evt    = (state == ST_REQ) && dma_req_i && grant_seen;
  assign withdraw_evt = (state == ST_REQ) && !dma_req_i;
  assign release_evt  = (state == ST_OWN) && dma_done_i;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (dma_req_i)    nxt = ST_REQ;
      ST_REQ: begin
        if (withdraw_evt)        nxt = ST_IDLE;
        else if (claim_evt)      nxt = ST_OWN;
      end
      ST_OWN:  if (release_evt)  nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= 1'b1;
      owned_q <= 1'b0;
    end else begin
      if (state == ST_IDLE) mode_q <= mode_i;
      state   <= nxt;
      owned_q <= (state == ST_OWN);
    end
  end

  assign req_oe_o    = (state == ST_REQ) && mode_q;
  assign req_n_o     = !req_oe_o;
  assign hold_oe_o   = !mode_q;
  assign hold_o      = !mode_q && (state != ST_IDLE);
  assign gack_oe_o   = mode_q && (state == ST_OWN);
  assign gack_n_o    = !gack_oe_o;
  assign bus_owned_o = owned_q && (state == ST_OWN);

  // R4: no three-wire claim without the qualifier
  a_r4_claim_qualified: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REQ && mode_q && !claim_ok_i) |=> (state != ST_OWN));

  // R6: no two-wire claim without hold acknowledge
  a_r6_hold_needed: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REQ && !mode_q && !hold_ack_s_i) |=> (state != ST_OWN));

  // R9: done while owning gives the bus back
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    release_evt |=> (state == ST_IDLE && !gack_oe_o && !hold_o));

  // R10: mode only moves in idle
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(mode_q));

  // R11: two-wire mode never touches grant-acknowledge
  a_r11_no_gack_mode0: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (!gack_oe_o && gack_n_o));

  // R12: a withdrawn request stops requesting
  a_r12_withdraw: assert property (@(posedge clk) disable iff (rst)
    withdraw_evt |=> (!req_oe_o && state == ST_IDLE));

  // R5: request dropped once grant-acknowledge is driven
  a_r5_req_off_when_owned: assert property (@(posedge clk) disable iff (rst)
    gack_oe_o |-> !req_oe_o);

endmodule

// File: rtl/bus_arb_front.sv
module bus_arb_front #(
  parameter int ACK_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             dma_req_i,
  input  logic             dma_done_i,
  input  logic             grant_n_i,
  input  logic             hold_ack_i,
  input  logic             strobe_n_i,
  input  logic [ACK_W-1:0] size_ack_n_i,
  input  logic             gack_n_i,
  output logic             req_n_o,
  output logic             req_oe_o,
  output logic             hold_o,
  output logic             hold_oe_o,
  output logic             gack_n_o,
  output logic             gack_oe_o,
  output logic             bus_owned_o
);

  localparam int SW = ACK_W + 4;
  localparam logic [SW-1:0] SYNC_IDLE = {1'b0, 1'b1, {ACK_W{1'b1}}, 1'b1, 1'b1};

  logic [SW-1:0]    raw_v, syn_v;
  logic             grant_n_s, strobe_n_s, gack_n_s, hold_ack_s;
  logic [ACK_W-1:0] size_ack_n_s;
  logic             claim_ok;

  assign raw_v = {hold_ack_i, gack_n_i, size_ack_n_i, strobe_n_i, grant_n_i};

  arb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_v),
    .q_o (syn_v)
  );

  assign grant_n_s    = syn_v[0];
  assign strobe_n_s   = syn_v[1];
  assign size_ack_n_s = syn_v[ACK_W+1:2];
  assign gack_n_s     = syn_v[ACK_W+2];
  assign hold_ack_s   = syn_v[ACK_W+3];

  arb_qual #(.ACK_W(ACK_W)) u_qual (
    .grant_n_s    (grant_n_s),
    .strobe_n_s   (strobe_n_s),
    .size_ack_n_s (size_ack_n_s),
    .gack_n_s     (gack_n_s),
    .claim_ok_o   (claim_ok)
  );

  arb_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .dma_req_i    (dma_req_i),
    .dma_done_i   (dma_done_i),
    .claim_ok_i   (claim_ok),
    .hold_ack_s_i (hold_ack_s),
    .req_n_o      (req_n_o),
    .req_oe_o     (req_oe_o),
    .hold_o       (hold_o),
    .hold_oe_o    (hold_oe_o),
    .gack_n_o     (gack_n_o),
    .gack_oe_o    (gack_oe_o),
    .bus_owned_o  (bus_owned_o)
  );

  // R8: ownership indication only follows an owned cycle
  a_r8_owned_late: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_owned_o) |-> $past(gack_oe_o || (hold_o && hold_oe_o)));

  // R2: request line only driven in three-wire mode and never with hold driven high
  a_r2_req_excl: assert property (@(posedge clk) disable iff (rst)
    req_oe_o |-> (!hold_oe_o && !req_n_o));

endmodule

// File: tb/sim_bus_arb_front.sv
module sim_bus_arb_front;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i = 1'b1, dma_req_i = 1'b0, dma_done_i = 1'b0;
  logic grant_n_i = 1'b1, hold_ack_i = 1'b0, strobe_n_i = 1'b1, gack_n_i = 1'b1;
  logic [1:0] size_ack_n_i = 2'b11;
  logic req_n_o, req_oe_o, hold_o, hold_oe_o, gack_n_o, gack_oe_o, bus_owned_o;

  int errs = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_arb_front u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .dma_req_i(dma_req_i),
    .dma_done_i(dma_done_i), .grant_n_i(grant_n_i), .hold_ack_i(hold_ack_i),
    .strobe_n_i(strobe_n_i), .size_ack_n_i(size_ack_n_i), .gack_n_i(gack_n_i),
    .req_n_o(req_n_o), .req_oe_o(req_oe_o), .hold_o(hold_o), .hold_oe_o(hold_oe_o),
    .gack_n_o(gack_n_o), .gack_oe_o(gack_oe_o), .bus_owned_o(bus_owned_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phase: 0 idle, 1 asking, 2 holding the bus
  int   m_phase = 0;
  bit   m_mode = 1, m_owned = 0, live = 0;
  logic [5:0] hist[$];

  always @(posedge clk) begin
    logic [5:0] old;
    bit was_holding;
    if (rst) begin
      m_phase = 0; m_mode = 1; m_owned = 0; live = 1;
      hist = {};
      hist.push_back(6'b011111);
      hist.push_back(6'b011111);
    end else begin
      old = hist.pop_front();
      hist.push_back({hold_ack_i, gack_n_i, size_ack_n_i, strobe_n_i, grant_n_i});
      was_holding = (m_phase == 2);
      if (m_phase == 0) begin
        m_mode = mode_i;
        if (dma_req_i) m_phase = 1;
      end else if (m_phase == 1) begin
        if (!dma_req_i) m_phase = 0;
        else if (m_mode ? (old[0] == 0 && old[1] == 1 && old[3:2] == 2'b11 && old[4] == 1)
                        : (old[5] == 1)) m_phase = 2;
      end else begin
        if (dma_done_i) m_phase = 0;
      end
      m_owned = was_holding;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R2 req_oe", req_oe_o, (m_phase == 1) && m_mode);
      chk("R2 req_n", req_n_o, !((m_phase == 1) && m_mode));
      chk("R3 hold_oe", hold_oe_o, !m_mode);
      chk("R3 hold", hold_o, !m_mode && m_phase != 0);
      chk("R4 gack_oe", gack_oe_o, m_mode && m_phase == 2);
      chk("R4 gack_n", gack_n_o, !(m_mode && m_phase == 2));
      chk("R8 owned", bus_owned_o, m_owned && m_phase == 2);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // ---------------- directed + random ----------------
  initial begin
    tick(2);
    // R1 reset state
    chk("R1 req_oe", req_oe_o, 1'b0);
    chk("R1 req_n", req_n_o, 1'b1);
    chk("R1 hold", hold_o, 1'b0);
    chk("R1 hold_oe", hold_oe_o, 1'b0);
    chk("R1 gack_oe", gack_oe_o, 1'b0);
    chk("R1 gack_n", gack_n_o, 1'b1);
    chk("R1 owned", bus_owned_o, 1'b0);
    rst = 1'b0;
    tick(2);

    // mode 1 clean claim
    dma_req_i = 1; tick();
    chk("R2 req driven", req_oe_o, 1'b1);
    chk("R2 req low", req_n_o, 1'b0);
    grant_n_i = 0; tick(2);
    chk("R7 not yet claimed", gack_oe_o, 1'b0);
    tick();
    chk("R7 R4 claimed", gack_oe_o, 1'b1);
    chk("R4 gack low", gack_n_o, 1'b0);
    chk("R5 req released", req_oe_o, 1'b0);
    chk("R8 owned late", bus_owned_o, 1'b0);
    tick();
    chk("R8 owned", bus_owned_o, 1'b1);
    mode_i = 0; tick(2);  // R10 ignored mid-transfer
    chk("R10 still three-wire", gack_oe_o, 1'b1);
    chk("R10 hold undriven", hold_oe_o, 1'b0);
    dma_done_i = 1; dma_req_i = 0; grant_n_i = 1; tick();
    dma_done_i = 0;
    chk("R9 gack undriven", gack_oe_o, 1'b0);
    chk("R8 owned falls", bus_owned_o, 1'b0);
    mode_i = 1; tick(3);

    // R4 each quiet condition broken in turn
    for (int k = 0; k < 4; k++) begin
      strobe_n_i   = (k == 0) ? 1'b0 : 1'b1;
      size_ack_n_i = (k == 1) ? 2'b10 : ((k == 2) ? 2'b01 : 2'b11);
      gack_n_i     = (k == 3) ? 1'b0 : 1'b1;
      grant_n_i = 0; dma_req_i = 1; tick(6);
      chk("R4 blocked", gack_oe_o, 1'b0);
      chk("R4 still asking", req_oe_o, 1'b1);
      strobe_n_i = 1; size_ack_n_i = 2'b11; gack_n_i = 1; tick(3);
      chk("R4 claims once quiet", gack_oe_o, 1'b1);
      dma_done_i = 1; dma_req_i = 0; grant_n_i = 1; tick();
      dma_done_i = 0; tick(2);
    end

    // R12 withdraw
    dma_req_i = 1; tick(2);
    dma_req_i = 0; tick();
    chk("R12 withdrawn", req_oe_o, 1'b0);
    chk("R12 request high", req_n_o, 1'b1);

    // mode 0
    mode_i = 0; tick();
    chk("R3 hold driven", hold_oe_o, 1'b1);
    chk("R3 hold low idle", hold_o, 1'b0);
    dma_req_i = 1; tick();
    chk("R3 hold high", hold_o, 1'b1);
    chk("R3 no req line", req_oe_o, 1'b0);
    hold_ack_i = 1; tick(2);
    chk("R7 hold not yet", bus_owned_o, 1'b0);
    tick(2);
    chk("R6 owned", bus_owned_o, 1'b1);
    chk("R6 hold kept", hold_o, 1'b1);
    chk("R11 no gack", gack_oe_o, 1'b0);
    chk("R11 gack high", gack_n_o, 1'b1);
    dma_done_i = 1; dma_req_i = 0; hold_ack_i = 0; tick();
    dma_done_i = 0;
    chk("R9 hold dropped", hold_o, 1'b0);

    // R1 reset mid-transfer
    dma_req_i = 1; hold_ack_i = 1; tick(5);
    rst = 1; tick();
    chk("R1 reset hold", hold_o, 1'b0);
    chk("R1 reset owned", bus_owned_o, 1'b0);
    rst = 0; dma_req_i = 0; hold_ack_i = 0; tick(2);

    // biased random run, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      if ((i % 500) == 0) mode_i = ~mode_i;
      dma_req_i    = ($urandom_range(9) < 7);
      dma_done_i   = ($urandom_range(7) == 0);
      grant_n_i    = ($urandom_range(3) == 0);
      hold_ack_i   = ($urandom_range(3) != 0);
      strobe_n_i   = ($urandom_range(5) != 0);
      size_ack_n_i = {($urandom_range(5) != 0), ($urandom_range(5) != 0)};
      gack_n_i     = ($urandom_range(7) != 0);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule